// File: doc/BRIEF.md
# Tick-Committed Register Front End

This block sits between a fast register bus and a peripheral whose state only advances on a slow periodic tick (typically once per second). A bus write to one of its deferred registers is not applied right away. The address and data are captured into a single holding slot, and the value lands in the target register on the next tick pulse. While the slot is occupied, a status flag reports it, and any further deferred write is thrown away without notice. When the held write lands, a completion flag is raised.

The event status register is the exception. Bus writes to it clear flags at once using write-one-to-clear, and they never occupy the holding slot. Event inputs from the timekeeping logic set its flags. An enable register decides which flags drive the interrupt line. The enable register itself is one of the deferred registers. Software therefore sees a changed enable mask only after the next tick.

Address map: 0 time (32 bits), 1 alarm (32 bits), 2 stopwatch (16 bits), 3 prescaler enable (1 bit), 4 interrupt enable (16 bits), 5 event status. Addresses 6 and 7 are unmapped. Reads are combinational on the address. The tick input is a single-cycle pulse that is already in the bus clock domain.

Top module: `slowsync_regfile`

## Requirements
- R1: A write to addresses 0 to 4 does not change the register's read-back until the clock edge of the next tick pulse on which the write is held. Read-back always returns the committed value.
- R2: A deferred write is discarded while a previous one is held. This includes a write presented in the same cycle as the tick that commits the held one; the held value is still committed.
- R3: Status bit 14 reads 1 exactly while a deferred write is held.
- R4: On the edge that commits a held write, bit 14 drops and status bit 15 (write done) sets.
- R5: A write to address 5 clears every status flag whose data bit is 1, in the next cycle. It neither uses nor disturbs the holding slot.
- R6: `irq` is high when any of status bits 15 or 6..0 is set and the enable bit at the same position is also set. Bit 14 never raises `irq`.
- R7: When a clear of an event flag and an `ev_set` pulse for that flag fall in the same cycle, the flag ends up set.
- R8: Writing 0xFFFF to address 5 clears all event flags and the done flag.
- R9: A deferred write accepted in the same cycle as a tick is not committed by that tick. It is committed by the following tick.
- R10: Stored widths are applied on commit: the stopwatch keeps bits 15..0, the prescaler enable keeps bit 0, and the interrupt enable keeps bits 15..0. Writes to addresses 6 and 7 have no effect, and reads of those addresses return 0.
- R11: After reset every register reads 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Single-cycle slow commit pulse |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| ev_set | input | 7 | Event pulses that set status bits 6..0 |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Interrupt request |

## Verification
Two operations can fall in the same cycle: a tick committing a held write and a new deferred write arriving, and a status clear arriving together with an event pulse on the same flag. The bench drives both pairs deliberately in a single cycle. It also drives them at random, alongside a behavioural model. Each outcome is judged at the ports: the committed value and the pending flag show which write survived, and the status read shows whether the flag held.

// File: rtl/slowsync_regfile.sv
module slowsync_regfile #(
  parameter int DW  = 32,
  parameter int AW  = 3,
  parameter int EVW = 7,
  parameter int SWW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  input  logic [EVW-1:0] ev_set,
  output logic [DW-1:0]  bus_rdata,
  output logic           irq
);
  localparam int SW = 16;
  localparam int BIT_PEND = 14;
  localparam int BIT_DONE = 15;
  localparam logic [AW-1:0] A_TIME = 0, A_ALRM = 1, A_SWCH = 2, A_PREN = 3, A_IEN = 4, A_STAT = 5;

  logic [DW-1:0]  time_q, alrm_q, hold_data_q;
  logic [SWW-1:0] swch_q;
  logic           pren_q;
  logic [SW-1:0]  ien_q;
  logic [EVW-1:0] ev_q;
  logic           done_q, pend_q;
  logic [AW-1:0]  hold_addr_q;
  logic [SW-1:0]  stat_w;

  wire defer_wr  = bus_wr && (bus_addr <= A_IEN);
  wire stat_wr   = bus_wr && (bus_addr == A_STAT);
  wire accept    = defer_wr && !pend_q;
  wire commit    = tick && pend_q;
  wire [EVW-1:0] ev_clr = stat_wr ? bus_wdata[EVW-1:0] : '0;
  wire           dn_clr = stat_wr && bus_wdata[BIT_DONE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0; alrm_q <= '0; swch_q <= '0; pren_q <= 1'b0; ien_q <= '0;
      ev_q <= '0; done_q <= 1'b0; pend_q <= 1'b0;
      hold_addr_q <= '0; hold_data_q <= '0;
    end else begin
      if (commit) begin
        pend_q <= 1'b0;
        case (hold_addr_q)
          A_TIME:  time_q <= hold_data_q;
          A_ALRM:  alrm_q <= hold_data_q;
          A_SWCH:  swch_q <= hold_data_q[SWW-1:0];
          A_PREN:  pren_q <= hold_data_q[0];
          A_IEN:   ien_q  <= hold_data_q[SW-1:0];
          default: ;
        endcase
      end
      if (accept) begin
        pend_q      <= 1'b1;
        hold_addr_q <= bus_addr;
        hold_data_q <= bus_wdata;
      end
      ev_q   <= (ev_q & ~ev_clr) | ev_set;
      done_q <= (done_q & ~dn_clr) | commit;
    end
  end

  always_comb begin
    stat_w = '0;
    stat_w[EVW-1:0] = ev_q;
    stat_w[BIT_PEND] = pend_q;
    stat_w[BIT_DONE] = done_q;
  end

  assign irq = |({done_q, ev_q} & {ien_q[BIT_DONE], ien_q[EVW-1:0]});

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_TIME:  bus_rdata = time_q;
      A_ALRM:  bus_rdata = alrm_q;
      A_SWCH:  bus_rdata[SWW-1:0] = swch_q;
      A_PREN:  bus_rdata[0] = pren_q;
      A_IEN:   bus_rdata[SW-1:0] = ien_q;
      A_STAT:  bus_rdata[SW-1:0] = stat_w;
      default: ;
    endcase
  end

  p_hold_until_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && pend_q) |=> $stable(time_q) && $stable(alrm_q) && $stable(swch_q)
                          && $stable(pren_q) && $stable(ien_q));

  p_drop_when_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !tick) |=> pend_q && $stable(hold_addr_q) && $stable(hold_data_q));

  p_commit_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend_q) |=> !pend_q && done_q);

  p_clear_no_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !pend_q) |=> !pend_q);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_set) |=> ((ev_q & $past(ev_set)) == $past(ev_set)));
endmodule

// File: tb/slowsync_regfile_bench.sv
module slowsync_regfile_bench;
  logic        clk = 0, rst_n = 0, tick = 0, bus_wr = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [6:0]  ev_set = 0;
  logic [31:0] bus_rdata;
  logic        irq;
  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  slowsync_regfile u_slowsync_regfile (.clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ev_set(ev_set), .bus_rdata(bus_rdata), .irq(irq));

  always #5 clk = ~clk;

  // behavioural reference
  logic [31:0] m_reg [0:4];
  logic        m_busy, m_done;
  int          m_haddr;
  logic [31:0] m_hdata;
  logic [6:0]  m_ev;

  function automatic logic [31:0] m_read(input int a);
    case (a)
      0, 1:    return m_reg[a];
      2:       return m_reg[2] & 32'hFFFF;
      3:       return m_reg[3] & 32'h1;
      4:       return m_reg[4] & 32'hFFFF;
      5:       return {16'h0, m_done, m_busy, 7'h0, m_ev};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic m_irq();
    return (m_done && m_reg[4][15]) || ((m_ev & m_reg[4][6:0]) != 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) m_reg[i] = 0;
      m_busy = 0; m_done = 0; m_haddr = 0; m_hdata = 0; m_ev = 0;
    end else begin
      logic was_busy, fired;
      was_busy = m_busy;
      fired = tick && was_busy;
      if (fired) begin m_reg[m_haddr] = m_hdata; m_busy = 0; end
      if (bus_wr && bus_addr < 5 && !was_busy) begin
        m_busy = 1; m_haddr = bus_addr; m_hdata = bus_wdata;
      end
      if (bus_wr && bus_addr == 5) begin
        m_ev = m_ev & ~bus_wdata[6:0];
        if (bus_wdata[15]) m_done = 0;
      end
      m_ev = m_ev | ev_set;
      if (fired) m_done = 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input int a, input logic [31:0] d, input logic t, input logic [6:0] e);
    check("model rdata", bus_rdata, m_read(int'(bus_addr)));
    check("model irq", {31'h0, irq}, {31'h0, m_irq()});
    bus_wr = w; bus_addr = a[2:0]; bus_wdata = d; tick = t; ev_set = e;
    @(negedge clk);
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    bus_wr = 0; tick = 0; ev_set = 0; bus_addr = a[2:0];
    #1 check(tag, bus_rdata, exp);
    @(negedge clk);
  endtask

  task automatic irqchk(input logic exp, input string tag);
    bus_wr = 0; tick = 0; ev_set = 0;
    #1 check(tag, {31'h0, irq}, {31'h0, exp});
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) rd(a, 0, "R11 reset read");
    irqchk(0, "R11 reset irq");

    step(1, 0, 32'h1234, 0, 0);
    rd(0, 0, "R1 time before tick");
    rd(5, 32'h4000, "R3 pending flag");
    step(1, 1, 32'hAAAA, 0, 0);
    step(0, 0, 0, 1, 0);
    rd(0, 32'h1234, "R1 time after tick");
    rd(5, 32'h8000, "R4 done set pending clear");
    rd(1, 0, "R2 dropped alarm write");

    step(1, 5, 32'h8000, 0, 0);
    rd(5, 0, "R5 immediate clear");

    step(1, 2, 32'hFFFFFFFF, 0, 0);
    step(0, 0, 0, 1, 0);
    rd(2, 32'hFFFF, "R10 stopwatch width");
    step(1, 5, 32'hFFFF, 0, 0);

    step(0, 0, 0, 0, 7'h04);
    rd(5, 32'h0004, "R7 event set");
    irqchk(0, "R6 masked event");
    step(1, 4, 32'h4004, 0, 0);
    irqchk(0, "R1 enable not yet committed");
    step(0, 0, 0, 1, 0);
    irqchk(1, "R6 enabled event irq");
    rd(4, 32'h4004, "R10 enable read-back");
    rd(5, 32'h8004, "R4 done after enable commit");

    step(1, 5, 32'h0004, 0, 7'h04);
    rd(5, 32'h8004, "R7 set beats clear");
    step(1, 5, 32'h0004, 0, 0);
    rd(5, 32'h8000, "R5 event cleared");
    irqchk(0, "R6 bit15 not enabled");

    step(1, 4, 32'h8000, 0, 0);
    step(0, 0, 0, 1, 0);
    irqchk(1, "R6 done irq");
    step(0, 0, 0, 0, 7'h7F);
    step(1, 5, 32'hFFFF, 0, 0);
    rd(5, 0, "R8 clear all");
    irqchk(0, "R8 irq low");

    step(1, 3, 32'hFFFFFFFF, 1, 0);
    rd(3, 0, "R9 not this tick");
    rd(5, 32'h4000, "R9 still pending");
    step(0, 0, 0, 1, 0);
    rd(3, 1, "R9 next tick / R10 bit0");

    step(1, 1, 32'h11, 0, 0);
    step(1, 1, 32'h22, 1, 0);
    rd(1, 32'h11, "R2 held write wins at tick");
    rd(5, 32'h8000, "R2 coincident write not held");

    step(1, 6, 32'hDEAD, 0, 0);
    step(1, 7, 32'hBEEF, 0, 0);
    rd(5, 32'h8000, "R10 unmapped no pending");
    rd(6, 0, "R10 unmapped read 6");
    rd(7, 0, "R10 unmapped read 7");

    step(1, 0, 32'h5, 0, 0);
    step(1, 5, 32'h8000, 0, 0);
    rd(5, 32'h4000, "R5 clear keeps slot");
    step(0, 0, 0, 1, 0);
    rd(0, 32'h5, "R5 slot commits after clear");

    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom_range(0, 7);
      step($urandom_range(0, 2) == 0, r, $urandom(), $urandom_range(0, 5) == 0,
           7'($urandom()) & 7'($urandom()));
    end
    step(0, 5, 0, 0, 0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule